// File: doc/BRIEF.md
# Two-Tank Water Fountain Controller

This block controls a drinking fountain that keeps one tank of hot water and one tank of cold water. Each tank reports four water-level flags and a temperature code in whole degrees Fahrenheit. A high-use input selects between the normal and the high-capacity thermal unit. From these inputs the block opens and closes each tank's fill valve and switches its heaters or coolers. It also decides whether the tank's water can be dispensed, and shows that decision on a green or red lamp and on the outlet-valve disable line.

All decisions are registered. Every output reflects the inputs sampled at the previous rising clock edge, combined with the block's own held hysteresis state. Three loops run per tank:

- a fill loop between the 80% and 95% level marks;
- a thermal loop between two temperature thresholds;
- a safety lockout, which a level below 20% sets and only a level above 30% clears.

While the lockout is set, the tank's thermal unit and its outlet are forced off. The temperature analog front end and the output drivers are outside the block.

Top module: `fountain_ctrl`

## Requirements
- R1: While reset is asserted, all heaters and coolers are off, both fill valves are closed, both outlets are disabled, both red lamps are on and both green lamps are off.
- R2: The hot-tank heat demand turns on when the hot code is 155 or lower. It turns off when the code is 160 or higher. Between those values it holds its previous state. Outputs follow one clock after the inputs.
- R3: The cold-tank cool demand turns on when the cold code is above 45. It turns off when the code is 40 or lower. Between those values it holds its previous state.
- R4: While high_use is 1, a demand drives only the high-capacity unit of that tank. While high_use is 0, it drives only the standard unit. The two units of a tank are never on together.
- R5: The level vector of each tank is {bit3 above 95%, bit2 above 80%, bit1 above 30%, bit0 above 20%}. The fill valve opens when bit2 is 0. It closes when bit2 and bit3 are both 1. Otherwise it holds its state.
- R6: When bit0 of a tank's level is 0, that tank's heaters or coolers go off and its outlet is disabled on the next clock.
- R7: After a lockout, the tank stays locked while bit1 is 0. Once it is released, the thermal demand restarts from off and turns on again only at the on-threshold.
- R8: The hot tank is available when its code is above 150, shown as green on and red off. Otherwise red is on and green is off. The hot outlet is disabled whenever the tank is unavailable or locked.
- R9: The cold tank is available when its code is below 50, with the same lamp and outlet rules as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| high_use | input | 1 | Selects the high-capacity thermal units |
| hot_lvl | input | 4 | Hot-tank level flags {95%, 80%, 30%, 20%} |
| cold_lvl | input | 4 | Cold-tank level flags {95%, 80%, 30%, 20%} |
| hot_temp | input | 8 | Hot-tank temperature code, degrees F |
| cold_temp | input | 8 | Cold-tank temperature code, degrees F |
| hot_fill | output | 1 | Hot-tank fill valve open |
| cold_fill | output | 1 | Cold-tank fill valve open |
| hot_outlet_dis | output | 1 | Hot outlet valve disabled |
| cold_outlet_dis | output | 1 | Cold outlet valve disabled |
| hot_green | output | 1 | Hot water available lamp |
| hot_red | output | 1 | Hot water unavailable lamp |
| cold_green | output | 1 | Cold water available lamp |
| cold_red | output | 1 | Cold water unavailable lamp |
| hot_std_heat | output | 1 | Standard heater on |
| hot_hc_heat | output | 1 | High-capacity heater on |
| cold_std_cool | output | 1 | Standard cooler on |
| cold_hc_cool | output | 1 | High-capacity cooler on |

## Verification
The assertions check the following on every cycle:

- the two units of a tank are never on together, and the lamps are never both on or both off;
- a level below 20% forces the thermal unit off and the outlet disabled one cycle later;
- the fill valve answers the 80% and 95% marks;
- the availability lamps track the temperature thresholds.

The hysteresis bands and the lockout release depend on history, so only the bench's scenarios can show them. These scenarios are slow temperature ramps in both directions, a sweep over every level-flag combination, and a release from lockout with the temperature inside the band.

// File: rtl/fountain_pkg.sv
package fountain_pkg;

    localparam int TEMP_W    = 8;
    localparam int NUM_TANKS = 2;
    localparam int HOT_IDX   = 0;
    localparam int COLD_IDX  = 1;

    // Thermal thresholds in whole degrees F
    localparam int HOT_ON_F   = 155;
    localparam int HOT_OFF_F  = 160;
    localparam int HOT_OK_F   = 150;
    localparam int COLD_ON_F  = 45;
    localparam int COLD_OFF_F = 40;
    localparam int COLD_OK_F  = 50;

    // Level flags; the bit order is the external encoding of the level ports
    typedef struct packed {
        logic above95;
        logic above80;
        logic above30;
        logic above20;
    } lvl_flags_t;

    typedef struct packed {
        logic fill;
        logic lock;
    } lvl_state_t;

    typedef struct packed {
        logic demand;
        logic std_on;
        logic hc_on;
        logic outlet_dis;
        logic green;
        logic red;
    } therm_state_t;

endpackage

// File: rtl/fountain_level_loop.sv
module fountain_level_loop
    import fountain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lvl_flags_t lvl,
    output logic       fill_o,
    output logic       lock_o,
    output logic       lock_nxt_o
);

    lvl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Fill loop: open below the lower mark, close at the upper mark
        if (!lvl.above80) begin
            st_d.fill = 1'b1;
        end else if (lvl.above95) begin
            st_d.fill = 1'b0;
        end
        // Safety lockout: set below the low mark, cleared above the release mark
        if (!lvl.above20) begin
            st_d.lock = 1'b1;
        end else if (lvl.above30) begin
            st_d.lock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fill_o     = st_q.fill;
    assign lock_o     = st_q.lock;
    assign lock_nxt_o = st_d.lock;

endmodule

// File: rtl/fountain_thermal_loop.sv
module fountain_thermal_loop
    import fountain_pkg::*;
#(
    parameter bit HEAT  = 1'b1,
    parameter int TW    = TEMP_W,
    parameter int ON_T  = HOT_ON_F,
    parameter int OFF_T = HOT_OFF_F,
    parameter int OK_T  = HOT_OK_F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] temp,
    input  logic          high_use,
    input  logic          lock_nxt,
    output logic          std_on_o,
    output logic          hc_on_o,
    output logic          outlet_dis_o,
    output logic          green_o,
    output logic          red_o
);

    localparam logic [TW-1:0] ON_C  = TW'(ON_T);
    localparam logic [TW-1:0] OFF_C = TW'(OFF_T);
    localparam logic [TW-1:0] OK_C  = TW'(OK_T);

    logic start_c;
    logic stop_c;
    logic ok_c;

    // The direction of every comparison depends on heating versus cooling
    generate
        if (HEAT) begin : g_heat
            assign start_c = (temp <= ON_C);
            assign stop_c  = (temp >= OFF_C);
            assign ok_c    = (temp >  OK_C);
        end else begin : g_cool
            assign start_c = (temp >  ON_C);
            assign stop_c  = (temp <= OFF_C);
            assign ok_c    = (temp <  OK_C);
        end
    endgenerate

    therm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lock_nxt) begin
            st_d.demand = 1'b0;
        end else if (start_c) begin
            st_d.demand = 1'b1;
        end else if (stop_c) begin
            st_d.demand = 1'b0;
        end
        st_d.std_on     = st_d.demand & ~high_use;
        st_d.hc_on      = st_d.demand &  high_use;
        st_d.green      = ok_c;
        st_d.red        = ~ok_c;
        st_d.outlet_dis = ~ok_c | lock_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.red        <= 1'b1;
            st_q.outlet_dis <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign std_on_o     = st_q.std_on;
    assign hc_on_o      = st_q.hc_on;
    assign outlet_dis_o = st_q.outlet_dis;
    assign green_o      = st_q.green;
    assign red_o        = st_q.red;

endmodule

// File: rtl/fountain_tank.sv
module fountain_tank
    import fountain_pkg::*;
#(
    parameter bit HEAT  = 1'b1,
    parameter int TW    = TEMP_W,
    parameter int ON_T  = HOT_ON_F,
    parameter int OFF_T = HOT_OFF_F,
    parameter int OK_T  = HOT_OK_F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    lvl_raw,
    input  logic [TW-1:0] temp,
    input  logic          high_use,
    output logic          fill_o,
    output logic          std_on_o,
    output logic          hc_on_o,
    output logic          outlet_dis_o,
    output logic          green_o,
    output logic          red_o
);

    lvl_flags_t lvl;
    logic       lock_q;
    logic       lock_nxt;

    assign lvl = lvl_flags_t'(lvl_raw);

    fountain_level_loop level_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (lvl),
        .fill_o     (fill_o),
        .lock_o     (lock_q),
        .lock_nxt_o (lock_nxt)
    );

    fountain_thermal_loop #(
        .HEAT  (HEAT),
        .TW    (TW),
        .ON_T  (ON_T),
        .OFF_T (OFF_T),
        .OK_T  (OK_T)
    ) thermal_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .temp         (temp),
        .high_use     (high_use),
        .lock_nxt     (lock_nxt),
        .std_on_o     (std_on_o),
        .hc_on_o      (hc_on_o),
        .outlet_dis_o (outlet_dis_o),
        .green_o      (green_o),
        .red_o        (red_o)
    );

    logic unused_lock;
    assign unused_lock = lock_q;

endmodule

// File: rtl/fountain_ctrl.sv
module fountain_ctrl
    import fountain_pkg::*;
#(
    parameter int TW         = TEMP_W,
    parameter int HOT_ON     = HOT_ON_F,
    parameter int HOT_OFF    = HOT_OFF_F,
    parameter int HOT_OK     = HOT_OK_F,
    parameter int COLD_ON    = COLD_ON_F,
    parameter int COLD_OFF   = COLD_OFF_F,
    parameter int COLD_OK    = COLD_OK_F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          high_use,
    input  logic [3:0]    hot_lvl,
    input  logic [3:0]    cold_lvl,
    input  logic [TW-1:0] hot_temp,
    input  logic [TW-1:0] cold_temp,
    output logic          hot_fill,
    output logic          cold_fill,
    output logic          hot_outlet_dis,
    output logic          cold_outlet_dis,
    output logic          hot_green,
    output logic          hot_red,
    output logic          cold_green,
    output logic          cold_red,
    output logic          hot_std_heat,
    output logic          hot_hc_heat,
    output logic          cold_std_cool,
    output logic          cold_hc_cool
);

    logic [3:0]    lvl_a  [NUM_TANKS];
    logic [TW-1:0] temp_a [NUM_TANKS];
    logic [NUM_TANKS-1:0] fill_a, std_a, hc_a, dis_a, grn_a, red_a;

    assign lvl_a[HOT_IDX]   = hot_lvl;
    assign lvl_a[COLD_IDX]  = cold_lvl;
    assign temp_a[HOT_IDX]  = hot_temp;
    assign temp_a[COLD_IDX] = cold_temp;

    generate
        for (genvar i = 0; i < NUM_TANKS; i++) begin : g_tank
            localparam bit IS_HOT = (i == HOT_IDX);
            fountain_tank #(
                .HEAT  (IS_HOT),
                .TW    (TW),
                .ON_T  (IS_HOT ? HOT_ON  : COLD_ON),
                .OFF_T (IS_HOT ? HOT_OFF : COLD_OFF),
                .OK_T  (IS_HOT ? HOT_OK  : COLD_OK)
            ) tank_i (
                .clk          (clk),
                .rst_n        (rst_n),
                .lvl_raw      (lvl_a[i]),
                .temp         (temp_a[i]),
                .high_use     (high_use),
                .fill_o       (fill_a[i]),
                .std_on_o     (std_a[i]),
                .hc_on_o      (hc_a[i]),
                .outlet_dis_o (dis_a[i]),
                .green_o      (grn_a[i]),
                .red_o        (red_a[i])
            );
        end
    endgenerate

    assign hot_fill        = fill_a[HOT_IDX];
    assign cold_fill       = fill_a[COLD_IDX];
    assign hot_outlet_dis  = dis_a[HOT_IDX];
    assign cold_outlet_dis = dis_a[COLD_IDX];
    assign hot_green       = grn_a[HOT_IDX];
    assign hot_red         = red_a[HOT_IDX];
    assign cold_green      = grn_a[COLD_IDX];
    assign cold_red        = red_a[COLD_IDX];
    assign hot_std_heat    = std_a[HOT_IDX];
    assign hot_hc_heat     = hc_a[HOT_IDX];
    assign cold_std_cool   = std_a[COLD_IDX];
    assign cold_hc_cool    = hc_a[COLD_IDX];

endmodule

// File: rtl/fountain_ctrl_chk.sv
module fountain_ctrl_chk
    import fountain_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              high_use,
    input logic [3:0]        hot_lvl,
    input logic [3:0]        cold_lvl,
    input logic [TEMP_W-1:0] hot_temp,
    input logic [TEMP_W-1:0] cold_temp,
    input logic              hot_fill,
    input logic              cold_fill,
    input logic              hot_outlet_dis,
    input logic              cold_outlet_dis,
    input logic              hot_green,
    input logic              hot_red,
    input logic              cold_green,
    input logic              cold_red,
    input logic              hot_std_heat,
    input logic              hot_hc_heat,
    input logic              cold_std_cool,
    input logic              cold_hc_cool
);

    localparam logic [TEMP_W-1:0] HOT_OK_C  = TEMP_W'(HOT_OK_F);
    localparam logic [TEMP_W-1:0] COLD_OK_C = TEMP_W'(COLD_OK_F);

    // R4: never both units of a tank
    p_unit_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(hot_std_heat && hot_hc_heat) && !(cold_std_cool && cold_hc_cool));

    // R4: high_use steers a running hot demand to the high-capacity unit
    p_hc_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_std_heat || hot_hc_heat) |-> (hot_hc_heat == $past(high_use)));

    // R6: hot lockout forces the heaters off and the outlet disabled
    p_hot_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hot_lvl[0] |=> (!hot_std_heat && !hot_hc_heat && hot_outlet_dis));

    // R6: cold lockout forces the coolers off and the outlet disabled
    p_cold_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cold_lvl[0] |=> (!cold_std_cool && !cold_hc_cool && cold_outlet_dis));

    // R5: fill valve opens below the 80% mark
    p_fill_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hot_lvl[2] |=> hot_fill);

    // R5: fill valve closes at the 95% mark
    p_fill_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cold_lvl[3] && cold_lvl[2]) |=> !cold_fill);

    // R8: hot lamps mirror the availability threshold
    p_hot_lamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hot_green == ($past(hot_temp) > HOT_OK_C)) && (hot_red != hot_green));

    // R9: cold lamps mirror the availability threshold; red implies a disabled outlet
    p_cold_lamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cold_green == ($past(cold_temp) < COLD_OK_C)) && (!cold_red || cold_outlet_dis));

endmodule

bind fountain_ctrl fountain_ctrl_chk chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .high_use        (high_use),
    .hot_lvl         (hot_lvl),
    .cold_lvl        (cold_lvl),
    .hot_temp        (hot_temp),
    .cold_temp       (cold_temp),
    .hot_fill        (hot_fill),
    .cold_fill       (cold_fill),
    .hot_outlet_dis  (hot_outlet_dis),
    .cold_outlet_dis (cold_outlet_dis),
    .hot_green       (hot_green),
    .hot_red         (hot_red),
    .cold_green      (cold_green),
    .cold_red        (cold_red),
    .hot_std_heat    (hot_std_heat),
    .hot_hc_heat     (hot_hc_heat),
    .cold_std_cool   (cold_std_cool),
    .cold_hc_cool    (cold_hc_cool)
);

// File: tb/fountain_ctrl_tb_top.sv
`timescale 1ns/1ps
module fountain_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       high_use = 1'b0;
    logic [3:0] hot_lvl = 4'hF;
    logic [3:0] cold_lvl = 4'hF;
    logic [7:0] hot_temp = 8'd170;
    logic [7:0] cold_temp = 8'd30;
    logic hot_fill, cold_fill, hot_outlet_dis, cold_outlet_dis;
    logic hot_green, hot_red, cold_green, cold_red;
    logic hot_std_heat, hot_hc_heat, cold_std_cool, cold_hc_cool;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench reference state, built from the requirements
    bit m_hfill, m_cfill, m_hlock, m_clock, m_hdem, m_cdem;

    always #2.5 clk = ~clk;

    fountain_ctrl dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .high_use        (high_use),
        .hot_lvl         (hot_lvl),
        .cold_lvl        (cold_lvl),
        .hot_temp        (hot_temp),
        .cold_temp       (cold_temp),
        .hot_fill        (hot_fill),
        .cold_fill       (cold_fill),
        .hot_outlet_dis  (hot_outlet_dis),
        .cold_outlet_dis (cold_outlet_dis),
        .hot_green       (hot_green),
        .hot_red         (hot_red),
        .cold_green      (cold_green),
        .cold_red        (cold_red),
        .hot_std_heat    (hot_std_heat),
        .hot_hc_heat     (hot_hc_heat),
        .cold_std_cool   (cold_std_cool),
        .cold_hc_cool    (cold_hc_cool)
    );

    task automatic chk(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit hok, cok;
        hok = (hot_temp > 8'd150);
        cok = (cold_temp < 8'd50);
        chk("R5", "hot_fill",  hot_fill,  m_hfill);
        chk("R5", "cold_fill", cold_fill, m_cfill);
        chk("R2", "hot_std_heat",  hot_std_heat,  m_hdem && !high_use);
        chk("R2", "hot_hc_heat",   hot_hc_heat,   m_hdem &&  high_use);
        chk("R3", "cold_std_cool", cold_std_cool, m_cdem && !high_use);
        chk("R3", "cold_hc_cool",  cold_hc_cool,  m_cdem &&  high_use);
        chk("R8", "hot_green", hot_green, hok);
        chk("R8", "hot_red",   hot_red,   !hok);
        chk("R8", "hot_outlet_dis", hot_outlet_dis, !hok || m_hlock);
        chk("R9", "cold_green", cold_green, cok);
        chk("R9", "cold_red",   cold_red,   !cok);
        chk("R9", "cold_outlet_dis", cold_outlet_dis, !cok || m_clock);
    endtask

    // Drive at the falling edge, advance the model, sample at the next falling edge
    task automatic apply(input logic [3:0] hl, input logic [3:0] cl,
                         input logic [7:0] ht, input logic [7:0] ct, input logic hu);
        hot_lvl = hl; cold_lvl = cl; hot_temp = ht; cold_temp = ct; high_use = hu;
        if (!hl[2]) m_hfill = 1; else if (hl[3]) m_hfill = 0;
        if (!cl[2]) m_cfill = 1; else if (cl[3]) m_cfill = 0;
        if (!hl[0]) m_hlock = 1; else if (hl[1]) m_hlock = 0;
        if (!cl[0]) m_clock = 1; else if (cl[1]) m_clock = 0;
        if (m_hlock) m_hdem = 0; else if (ht <= 155) m_hdem = 1; else if (ht >= 160) m_hdem = 0;
        if (m_clock) m_cdem = 0; else if (ct > 45) m_cdem = 1; else if (ct <= 40) m_cdem = 0;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "hot_fill", hot_fill, 1'b0);
        chk("R1", "cold_fill", cold_fill, 1'b0);
        chk("R1", "heaters", hot_std_heat | hot_hc_heat, 1'b0);
        chk("R1", "coolers", cold_std_cool | cold_hc_cool, 1'b0);
        chk("R1", "outlets_dis", hot_outlet_dis & cold_outlet_dis, 1'b1);
        chk("R1", "reds", hot_red & cold_red, 1'b1);
        chk("R1", "greens", hot_green | cold_green, 1'b0);
        rst_n = 1'b1;

        // R8 R9: full temperature sweep on both tanks at full level
        for (int t = 0; t < 256; t++) apply(4'hF, 4'hF, 8'(t), 8'(255 - t), 1'b0);

        // R2 R3: slow ramps through the hysteresis bands
        for (int t = 170; t >= 140; t--) apply(4'hF, 4'hF, 8'(t), 8'(t - 120), 1'b0);
        for (int t = 140; t <= 170; t++) apply(4'hF, 4'hF, 8'(t), 8'(t - 120), 1'b0);
        for (int t = 170; t >= 140; t--) apply(4'hF, 4'hF, 8'(t), 8'(t - 120), 1'b0);

        // R4: demand held in band, toggle high_use
        apply(4'hF, 4'hF, 8'd150, 8'd48, 1'b0);
        apply(4'hF, 4'hF, 8'd157, 8'd43, 1'b1);
        chk("R4", "hot_hc_heat", hot_hc_heat, 1'b1);
        chk("R4", "cold_hc_cool", cold_hc_cool, 1'b1);
        apply(4'hF, 4'hF, 8'd157, 8'd43, 1'b0);
        chk("R4", "hot_std_heat", hot_std_heat, 1'b1);
        chk("R4", "hot_hc_heat_off", hot_hc_heat, 1'b0);

        // R5: fill sequence
        apply(4'b0111, 4'b0111, 8'd165, 8'd35, 1'b0);
        apply(4'b0011, 4'b0011, 8'd165, 8'd35, 1'b0);
        chk("R5", "fill_open", hot_fill & cold_fill, 1'b1);
        apply(4'b0111, 4'b0111, 8'd165, 8'd35, 1'b0);
        chk("R5", "fill_hold_open", hot_fill, 1'b1);
        apply(4'b1111, 4'b1111, 8'd165, 8'd35, 1'b0);
        apply(4'b0111, 4'b0111, 8'd165, 8'd35, 1'b0);
        chk("R5", "fill_hold_closed", cold_fill, 1'b0);

        // R6 R7: lockout and release on both tanks
        apply(4'b0011, 4'b0011, 8'd150, 8'd48, 1'b0);
        apply(4'b0000, 4'b0000, 8'd150, 8'd48, 1'b0);
        chk("R6", "hot_heat_forced_off", hot_std_heat, 1'b0);
        chk("R6", "cold_cool_forced_off", cold_std_cool, 1'b0);
        chk("R6", "hot_outlet_dis", hot_outlet_dis, 1'b1);
        apply(4'b0001, 4'b0001, 8'd157, 8'd43, 1'b0);
        chk("R7", "still_locked", hot_outlet_dis & cold_outlet_dis, 1'b1);
        apply(4'b0011, 4'b0011, 8'd157, 8'd43, 1'b0);
        chk("R7", "released_no_restart_hot", hot_std_heat, 1'b0);
        chk("R7", "released_no_restart_cold", cold_std_cool, 1'b0);
        chk("R7", "released_outlet", cold_outlet_dis, 1'b0);
        apply(4'b0011, 4'b0011, 8'd155, 8'd46, 1'b0);
        chk("R7", "restart_hot", hot_std_heat, 1'b1);
        chk("R7", "restart_cold", cold_std_cool, 1'b1);

        // R5 R6 R7: every level combination, twice in differing orders, in-band temps
        for (int r = 0; r < 2; r++) begin
            for (int v = 0; v < 16; v++) begin
                apply(4'(v), 4'(15 - v), 8'd153, 8'd47, 1'(r));
                apply(4'(v ^ 5), 4'(v), 8'd158, 8'd42, 1'(v & 1));
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule